// File: doc/BRIEF.md
# CRC7 Command Frame Builder

This block forms the command phase of a register and bulk-transfer protocol that runs over a byte-wide serial link. A request carries an opcode, a 24-bit address, a 24-bit transfer size, 32-bit write data and a clockless flag. The block checks the opcode and lays out the frame bytes that opcode calls for. It then hands the frame out one byte at a time on a valid/ready byte stream. When checking is switched on, the frame ends with a CRC7 byte.

The serial shifter sits downstream of the byte stream, and the response parser is a separate block. The total frame length is reported as soon as a request is accepted, so the shifter can size its transfer before the first byte arrives. An opcode outside the supported set produces a one-cycle error pulse and no bytes.

Top module: `cmd_frame_builder`

## Requirements
- R1: After a synchronous reset, `busy`, `out_valid` and `err_pulse` are low.
- R2: The legal opcodes are 0xC1 to 0xCA and 0xCF. Any other opcode accepted while idle raises `err_pulse` for exactly one cycle, starts no frame and leaves the block idle.
- R3: Opcode 0xCA sends the opcode and then address bytes [23:16], [15:8] and [7:0]. Opcode 0xC9 sends the same bytes followed by write data bytes [31:24], [23:16], [15:8] and [7:0].
- R4: Opcodes 0xC4 and 0xC3 send the opcode, then address[15:8] with bit 7 forced to 1 when `req_clockless` is 1, then address[7:0]. After that, 0xC4 sends one 0x00 byte and 0xC3 sends the four write data bytes, most significant byte first. `req_clockless` has no effect on any other opcode.
- R5: Opcodes 0xC5 and 0xC6 send three 0x00 bytes after the opcode. Opcode 0xCF sends three 0xFF bytes after the opcode.
- R6: Opcodes 0xC1 and 0xC2 send the opcode, three address bytes and then size[15:0], most significant byte first. Opcodes 0xC7 and 0xC8 send the opcode, three address bytes and then size[23:0], most significant byte first.
- R7: When CRC is enabled, one extra byte ends the frame. Its bits [7:1] hold the CRC7 (polynomial x^7+x^3+1, register preset to 0x7F, data taken most significant bit first) of all earlier frame bytes, and its bit 0 is 0.
- R8: When `crc_enable` is 0 at acceptance, the CRC byte is left out. `frame_len` gives the total number of bytes in the frame from the cycle after acceptance: 5, 5, 5, 7, 8, 8 or 9 with CRC, and one less without it.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. `out_last` is high only on the final byte of the frame.
- R10: `busy` rises in the cycle after a legal request is accepted and falls right after the final byte is taken. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_opcode | input | 8 | Command opcode |
| req_addr | input | 24 | Target address |
| req_size | input | 24 | Transfer size for the bulk commands |
| req_wdata | input | 32 | Write data for the single-word and internal writes |
| req_clockless | input | 1 | Sets bit 7 of the upper address byte on internal commands |
| crc_enable | input | 1 | Appends the CRC7 byte when high |
| busy | output | 1 | A frame is being sent |
| err_pulse | output | 1 | One-cycle flag for an unsupported opcode |
| frame_len | output | 4 | Total byte count of the current frame |
| out_valid | output | 1 | `out_data` holds a frame byte |
| out_ready | input | 1 | The consumer takes the byte this cycle |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The hardest case to reach is a CRC byte that waits under backpressure while a competing request sits at the input. The stored checksum has to survive both stalled cycles and a request that must not be taken. The bench covers this by sweeping all 256 opcode values under each CRC and clockless setting. It throttles `out_ready` with a pattern that shifts from frame to frame, and it holds a conflicting legal request on the input for the whole time the frame is being sent. Each collected frame is compared with a layout and checksum the bench builds on its own, using a byte-aligned CRC formulation.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
    localparam int ADDR_W   = 24;
    localparam int SIZE_W   = 24;
    localparam int DATA_W   = 32;
    localparam int MAX_BODY = 8;
    localparam int LEN_W    = 4;
    localparam int CRC_W    = 7;
    localparam logic [CRC_W-1:0] CRC_SEED = 7'h7F;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    typedef enum logic [7:0] {
        OP_BULK_WR   = 8'hC1,
        OP_BULK_RD   = 8'hC2,
        OP_LOCAL_WR  = 8'hC3,
        OP_LOCAL_RD  = 8'hC4,
        OP_STOP      = 8'hC5,
        OP_AGAIN     = 8'hC6,
        OP_XBULK_WR  = 8'hC7,
        OP_XBULK_RD  = 8'hC8,
        OP_WORD_WR   = 8'hC9,
        OP_WORD_RD   = 8'hCA,
        OP_RESTART   = 8'hCF
    } op_e;

    typedef logic [MAX_BODY-1:0][7:0] body_t;

    typedef struct packed {
        body_t            bytes;
        logic [LEN_W-1:0] len;
        logic             legal;
    } layout_t;

    // One byte into a CRC7 register, MSB first, bit by bit.
    function automatic logic [CRC_W-1:0] crc7_byte(input logic [CRC_W-1:0] c_in,
                                                   input logic [7:0] d);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction
endpackage

// File: rtl/cfb_layout.sv
module cfb_layout
    import cfb_pkg::*;
(
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clockless,
    output layout_t           lay
);
    logic [7:0] a_hi, a_mid, a_lo, a_int_hi;

    assign a_hi     = addr[23:16];
    assign a_mid    = addr[15:8];
    assign a_lo     = addr[7:0];
    assign a_int_hi = {addr[15] | clockless, addr[14:8]};

    always_comb begin
        lay.bytes    = '0;
        lay.len      = '0;
        lay.legal    = 1'b1;
        lay.bytes[0] = opcode;
        case (opcode)
            OP_WORD_RD: begin
                lay.bytes[3:1] = {a_lo, a_mid, a_hi};
                lay.len = 4'd4;
            end
            OP_WORD_WR: begin
                lay.bytes[3:1] = {a_lo, a_mid, a_hi};
                lay.bytes[7:4] = {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]};
                lay.len = 4'd8;
            end
            OP_LOCAL_RD: begin
                lay.bytes[3:1] = {8'h00, a_lo, a_int_hi};
                lay.len = 4'd4;
            end
            OP_LOCAL_WR: begin
                lay.bytes[2:1] = {a_lo, a_int_hi};
                lay.bytes[6:3] = {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]};
                lay.len = 4'd7;
            end
            OP_STOP, OP_AGAIN: begin
                lay.len = 4'd4;
            end
            OP_RESTART: begin
                lay.bytes[3:1] = {3{8'hFF}};
                lay.len = 4'd4;
            end
            OP_BULK_WR, OP_BULK_RD: begin
                lay.bytes[3:1] = {a_lo, a_mid, a_hi};
                lay.bytes[5:4] = {size[7:0], size[15:8]};
                lay.len = 4'd6;
            end
            OP_XBULK_WR, OP_XBULK_RD: begin
                lay.bytes[3:1] = {a_lo, a_mid, a_hi};
                lay.bytes[6:4] = {size[7:0], size[15:8], size[23:16]};
                lay.len = 4'd7;
            end
            default: begin
                lay.legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cfb_crc7.sv
module cfb_crc7
    import cfb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             seed,
    input  logic             step,
    input  logic [7:0]       din,
    output logic [CRC_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || seed) crc <= CRC_SEED;
        else if (step)   crc <= crc7_byte(crc, din);
    end
endmodule

// File: rtl/cmd_frame_builder.sv
module cmd_frame_builder
    import cfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [7:0]        req_opcode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_clockless,
    input  logic              crc_enable,
    output logic              busy,
    output logic              err_pulse,
    output logic [LEN_W-1:0]  frame_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last
);
    layout_t          lay;
    body_t            body_q;
    logic [LEN_W-1:0] blen_q, idx_q, total;
    logic             crc_on_q, busy_q, err_q;
    logic             accept, take, in_body;
    logic [CRC_W-1:0] crc;

    cfb_layout u_layout (
        .opcode    (req_opcode),
        .addr      (req_addr),
        .size      (req_size),
        .wdata     (req_wdata),
        .clockless (req_clockless),
        .lay       (lay)
    );

    assign accept  = req_valid && !busy_q;
    assign take    = busy_q && out_ready;
    assign total   = blen_q + {{(LEN_W-1){1'b0}}, crc_on_q};
    assign in_body = idx_q < blen_q;

    cfb_crc7 u_crc (
        .clk  (clk),
        .rst  (rst),
        .seed (accept),
        .step (take && in_body),
        .din  (body_q[idx_q[2:0]]),
        .crc  (crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            err_q     <= 1'b0;
            idx_q     <= '0;
            blen_q    <= '0;
            crc_on_q  <= 1'b0;
            body_q    <= '0;
            frame_len <= '0;
        end else begin
            err_q <= accept && !lay.legal;
            if (accept && lay.legal) begin
                busy_q    <= 1'b1;
                idx_q     <= '0;
                body_q    <= lay.bytes;
                blen_q    <= lay.len;
                crc_on_q  <= crc_enable;
                frame_len <= lay.len + {{(LEN_W-1){1'b0}}, crc_enable};
            end else if (take) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == total - 1'b1) busy_q <= 1'b0;
            end
        end
    end

    assign busy      = busy_q;
    assign err_pulse = err_q;
    assign out_valid = busy_q;
    assign out_data  = in_body ? body_q[idx_q[2:0]] : {crc, 1'b0};
    assign out_last  = busy_q && (idx_q == total - 1'b1);
endmodule

// File: rtl/cmd_frame_builder_chk.sv
module cmd_frame_builder_chk
    import cfb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             err_pulse,
    input logic [LEN_W-1:0] frame_len,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last
);
    logic [LEN_W-1:0] sent;
    always_ff @(posedge clk) begin
        if (rst) sent <= '0;
        else if (out_valid && out_ready) sent <= out_last ? '0 : sent + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !busy && !out_valid && !err_pulse);
    // R2
    err_single_chk: assert property (@(posedge clk) disable iff (rst) err_pulse |=> !err_pulse);
    // R2
    err_idle_chk: assert property (@(posedge clk) disable iff (rst) err_pulse |-> !busy && !out_valid);
    // R8
    len_match_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |-> (sent + 1'b1 == frame_len));
    // R9
    hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));
    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !busy);
endmodule

bind cmd_frame_builder cmd_frame_builder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .err_pulse (err_pulse),
    .frame_len (frame_len),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/cmd_frame_builder_test.sv
`timescale 1ns/1ps
module cmd_frame_builder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_opcode = 8'h00;
    logic [23:0] req_addr = '0;
    logic [23:0] req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_clockless = 1'b0;
    logic        crc_enable = 1'b0;
    logic        out_ready = 1'b0;
    logic        busy, err_pulse, out_valid, out_last;
    logic [3:0]  frame_len;
    logic [7:0]  out_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cmd_frame_builder uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_clockless(req_clockless), .crc_enable(crc_enable), .busy(busy),
        .err_pulse(err_pulse), .frame_len(frame_len), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    logic [7:0] exp_b [0:8];
    int         exp_n;
    bit         exp_ok;
    logic [7:0] got_b [0:15];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'hC9, 8'hCA: return "R3";
            8'hC3, 8'hC4: return "R4";
            8'hC5, 8'hC6, 8'hCF: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Expected frame built from the requirement text; CRC done byte-aligned.
    task automatic build(input logic [7:0] op, input logic [23:0] a, input logic [23:0] s,
                         input logic [31:0] w, input bit cl, input bit ce);
        logic [7:0] c;
        logic [7:0] ih;
        ih = a[15:8] | (cl ? 8'h80 : 8'h00);
        exp_ok = 1;
        exp_b[0] = op;
        case (op)
            8'hCA: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0]; exp_n=4; end
            8'hC9: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                         exp_b[4]=w[31:24]; exp_b[5]=w[23:16]; exp_b[6]=w[15:8]; exp_b[7]=w[7:0]; exp_n=8; end
            8'hC4: begin exp_b[1]=ih; exp_b[2]=a[7:0]; exp_b[3]=8'h00; exp_n=4; end
            8'hC3: begin exp_b[1]=ih; exp_b[2]=a[7:0];
                         exp_b[3]=w[31:24]; exp_b[4]=w[23:16]; exp_b[5]=w[15:8]; exp_b[6]=w[7:0]; exp_n=7; end
            8'hC5, 8'hC6: begin exp_b[1]=0; exp_b[2]=0; exp_b[3]=0; exp_n=4; end
            8'hCF: begin exp_b[1]=8'hFF; exp_b[2]=8'hFF; exp_b[3]=8'hFF; exp_n=4; end
            8'hC1, 8'hC2: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                         exp_b[4]=s[15:8]; exp_b[5]=s[7:0]; exp_n=6; end
            8'hC7, 8'hC8: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                         exp_b[4]=s[23:16]; exp_b[5]=s[15:8]; exp_b[6]=s[7:0]; exp_n=7; end
            default: begin exp_ok = 0; exp_n = 0; end
        endcase
        if (exp_ok && ce) begin
            c = 8'hFE;
            for (int i = 0; i < exp_n; i++) begin
                c = c ^ exp_b[i];
                for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h12) : (c << 1);
            end
            exp_b[exp_n] = c & 8'hFE;
            exp_n = exp_n + 1;
        end
    endtask

    task automatic run_one(input logic [7:0] op, input bit cl, input bit ce, input int seed);
        logic [23:0] a;
        logic [23:0] s;
        logic [31:0] w;
        int nb;
        bit got_last;
        bit stall_prev;
        logic [7:0] stall_d;
        logic stall_l;
        bit frame_ok;
        int guard;
        a = {op ^ 8'h3C, 8'h5A + op, ~op};
        s = {8'h11 + op, op, 8'hE7 ^ op};
        w = {op, 8'hA5, ~op, 8'h96 + op};
        build(op, a, s, w, cl, ce);
        @(negedge clk);
        req_valid = 1; req_opcode = op; req_addr = a; req_size = s;
        req_wdata = w; req_clockless = cl; crc_enable = ce; out_ready = 0;
        @(negedge clk);
        // competing legal request held during the frame (must be ignored)
        req_opcode = 8'hC9; req_addr = ~a; req_wdata = ~w; req_size = ~s;
        req_clockless = ~cl; crc_enable = ~ce;
        req_valid = exp_ok;
        #1;
        if (!exp_ok) begin
            check(err_pulse == 1 && busy == 0 && out_valid == 0, "R2 err/idle",
                  {err_pulse, busy, out_valid}, 3'b100);
            @(negedge clk); #1;
            check(err_pulse == 0 && busy == 0, "R2 single pulse", {err_pulse, busy}, 0);
            return;
        end
        check(busy == 1 && frame_len == exp_n, "R8 frame_len", frame_len, exp_n);
        nb = 0; got_last = 0; stall_prev = 0; frame_ok = 1; guard = 0;
        stall_d = 0; stall_l = 0;
        while (!got_last && guard < 100) begin
            @(negedge clk);
            out_ready = ((guard + seed) % 3) != 0 || seed[2];
            guard++;
            #1;
            if (stall_prev)
                check(out_valid && out_data == stall_d && out_last == stall_l, "R9 hold",
                      out_data, stall_d);
            if (out_valid && out_ready) begin
                got_b[nb] = out_data;
                if (out_last) got_last = 1;
                check(out_last == (nb == exp_n - 1), "R9 last flag", out_last, nb == exp_n - 1);
                nb++;
            end
            stall_prev = out_valid && !out_ready;
            stall_d = out_data; stall_l = out_last;
        end
        @(negedge clk);
        req_valid = 0; out_ready = 0;
        #1;
        check(busy == 0 && out_valid == 0, "R10 busy drop / request ignored", busy, 0);
        check(nb == exp_n, "R8 byte count", nb, exp_n);
        for (int i = 0; i < exp_n && i < nb; i++) if (got_b[i] != exp_b[i]) frame_ok = 0;
        check(frame_ok, $sformatf("%s layout op=%0h", tag_of(op), op), nb > 0 ? got_b[0] : 0, op);
        if (ce && nb == exp_n)
            check(got_b[nb-1] == exp_b[exp_n-1], "R7 crc byte", got_b[nb-1], exp_b[exp_n-1]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(busy == 0 && out_valid == 0 && err_pulse == 0, "R1 reset state",
              {busy, out_valid, err_pulse}, 0);
        @(negedge clk);
        rst = 0;
        for (int op = 0; op < 256; op++)
            for (int m = 0; m < 4; m++)
                run_one(op[7:0], m[1], m[0], op * 4 + m);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule